// File: doc/BRIEF.md
# Cycle-Stealing Dual-Address DMA Engine

This block is a single-channel DMA engine. It copies a run of data units from a source region to a destination region over a 16-bit master bus. Each unit is a byte, a 16-bit word or a 32-bit longword. It is moved by read cycles from the source followed by write cycles to the destination. Every bus access lasts two clock cycles.

The engine steals the bus one unit at a time. It requests the bus, moves one unit, then drops its request for at least one clock so that another master can be granted in between. A longword is split into two word accesses, at the address and at the address plus two. The halves are gathered in a 32-bit holding register before the writes begin, so a longword need not sit on a 4-byte boundary.

Software loads source, destination, unit count, unit size and the transfer-end enable, then pulses start. It waits for the done flag. Addresses of word and longword units must be even.

Top module: `dma_steal_engine`

## Requirements
- R1: `cfg_unit` selects the unit size: 00 is a byte, 01 is a word, 10 or 11 is a longword. Each unit is read completely from the source before any of it is written to the destination.
- R2: A longword is moved as a word read at the source address, a word read at source+2, a word write at the destination address and a word write at destination+2. The first word read is the first word written. This holds when either address is 2 modulo 4.
- R3: `bus_rd` and `bus_wr` are only active while `bus_req` is high, and a unit starts only after `bus_gnt` is seen with `bus_req` high. After each unit, `bus_req` is low for at least one clock, so a transfer of N units shows N rising edges of `bus_req`.
- R4: Every bus access holds `bus_rd` or `bus_wr` for exactly two clocks, and the two strobes are never active together. A transfer of N units with B word accesses per unit shows 2·N·B read cycles.
- R5: After each unit, the source and destination addresses each advance by the unit size (1, 2 or 4) and the count drops by one. The transfer stops after the unit that takes the count from 1 to 0.
- R6: `bus_ben[1]` enables data bits 15:8 (the even byte) and `bus_ben[0]` enables bits 7:0 (the odd byte). A byte access enables only the lane chosen by address bit 0. Word and longword accesses enable both lanes, and the bus address bit 0 is forced to 0 for them.
- R7: When `cfg_end_en` was set at start, `xfer_end` is high during every bus access of the last unit and at no other time. When it was clear, `xfer_end` stays low.
- R8: After reset `busy`, `done`, `bus_req` and `xfer_end` are low. An accepted start clears `done` and raises `busy`. Completion of the final write sets `done` and lowers `busy`.
- R9: A start pulse while `busy` is high is ignored: the running transfer finishes with its original settings and no other memory is written.
- R10: A start with a count of zero sets `done` on the next clock without any bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_count | input | CW | Number of units to move |
| cfg_unit | input | 2 | Unit size select |
| cfg_end_en | input | 1 | Enable for the transfer-end output |
| cfg_start | input | 1 | Start pulse; configuration is latched here |
| busy | output | 1 | Channel is active |
| done | output | 1 | Last transfer completed |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | AW | Byte address of the current access |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_ben | output | 2 | Byte lane enables (1: bits 15:8, 0: bits 7:0) |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, sampled at the end of the second read cycle |
| xfer_end | output | 1 | High during accesses of the final unit |

## Verification
The hardest case to reach is a longword whose source or destination is 2 modulo 4. The unit then straddles a 4-byte boundary while the grant arrives late and at random. The holding register must keep the first half across the second read, and the write order must match the read order. Directed runs place the source and the destination at such addresses in turn. A random-delay arbiter in the bench varies the grant latency of every unit. Random runs then mix all three unit sizes with odd byte addresses and unaligned longwords against a memory image that the bench computes as a plain byte copy.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

  localparam int BUS_W  = 16;
  localparam int HOLD_W = 32;

  localparam logic [1:0] UNIT_BYTE = 2'b00;
  localparam logic [1:0] UNIT_WORD = 2'b01;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_ARB,
    SEQ_READ,
    SEQ_WRITE,
    SEQ_GAP
  } seq_st_e;

  // bytes moved per unit
  function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      UNIT_BYTE: return 3'd1;
      UNIT_WORD: return 3'd2;
      default:   return 3'd4;
    endcase
  endfunction

  // a unit needs two word beats only when it is a longword
  function automatic logic two_beats(input logic [1:0] sz);
    return (sz != UNIT_BYTE) && (sz != UNIT_WORD);
  endfunction

  // byte offset of a beat within a unit
  function automatic logic [2:0] beat_offset(input logic beat);
    return beat ? 3'd2 : 3'd0;
  endfunction

  // lane enables: bit 1 = even byte (15:8), bit 0 = odd byte (7:0)
  function automatic logic [1:0] lane_sel(input logic [1:0] sz, input logic a0);
    if (sz == UNIT_BYTE) return a0 ? 2'b01 : 2'b10;
    return 2'b11;
  endfunction

endpackage

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt
  import dma_steal_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic [CW-1:0] ld_cnt,
  input  logic [1:0]    size,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output logic          last_unit
);

  logic [AW-1:0] step;
  assign step      = AW'(unit_bytes(size));
  assign last_unit = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src <= '0;
      dst <= '0;
      cnt <= '0;
    end else if (load) begin
      src <= ld_src;
      dst <= ld_dst;
      cnt <= ld_cnt;
    end else if (adv) begin
      src <= src + step;
      dst <= dst + step;
      cnt <= cnt - CW'(1);
    end
  end

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_steal_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_ok,
  input  logic    zero_cnt,
  input  logic    gnt,
  input  logic    long_unit,
  input  logic    last_unit,
  output seq_st_e state,
  output logic    phase,
  output logic    beat,
  output logic    rd_cap,
  output logic    unit_done,
  output logic    final_done,
  output logic    req,
  output logic    rd,
  output logic    wr
);

  logic beat_last;
  assign beat_last = (beat == long_unit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      phase <= 1'b0;
      beat  <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (start_ok && !zero_cnt) state <= SEQ_ARB;
        end
        SEQ_ARB: begin
          if (gnt) begin
            state <= SEQ_READ;
            phase <= 1'b0;
            beat  <= 1'b0;
          end
        end
        SEQ_READ: begin
          if (!phase) begin
            phase <= 1'b1;
          end else begin
            phase <= 1'b0;
            if (!beat_last) begin
              beat <= 1'b1;
            end else begin
              beat  <= 1'b0;
              state <= SEQ_WRITE;
            end
          end
        end
        SEQ_WRITE: begin
          if (!phase) begin
            phase <= 1'b1;
          end else begin
            phase <= 1'b0;
            if (!beat_last) begin
              beat <= 1'b1;
            end else begin
              beat  <= 1'b0;
              state <= last_unit ? SEQ_IDLE : SEQ_GAP;
            end
          end
        end
        SEQ_GAP: state <= SEQ_ARB;
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign rd         = (state == SEQ_READ);
  assign wr         = (state == SEQ_WRITE);
  assign req        = (state == SEQ_ARB) || rd || wr;
  assign rd_cap     = rd && phase;
  assign unit_done  = wr && phase && beat_last;
  assign final_done = unit_done && last_unit;

endmodule

// File: rtl/dma_hold_path.sv
module dma_hold_path
  import dma_steal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic             beat,
  input  logic [1:0]       size,
  input  logic             src_a0,
  input  logic [BUS_W-1:0] rdata,
  output logic [BUS_W-1:0] wdata
);

  logic [HOLD_W-1:0] hold;
  logic [7:0]        rbyte;

  assign rbyte = src_a0 ? rdata[7:0] : rdata[15:8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
    end else if (cap) begin
      if (size == UNIT_BYTE)      hold[7:0]   <= rbyte;
      else if (size == UNIT_WORD) hold[15:0]  <= rdata;
      else if (beat)              hold[15:0]  <= rdata;
      else                        hold[31:16] <= rdata;
    end
  end

  always_comb begin
    if (size == UNIT_BYTE)      wdata = {hold[7:0], hold[7:0]};
    else if (size == UNIT_WORD) wdata = hold[15:0];
    else if (beat)              wdata = hold[15:0];
    else                        wdata = hold[31:16];
  end

endmodule

// File: rtl/dma_steal_engine.sv
module dma_steal_engine
  import dma_steal_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    cfg_unit,
  input  logic          cfg_end_en,
  input  logic          cfg_start,
  output logic          busy,
  output logic          done,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [1:0]    bus_ben,
  output logic [15:0]   bus_wdata,
  input  logic [15:0]   bus_rdata,
  output logic          xfer_end
);

  seq_st_e       state;
  logic          phase, beat;
  logic          rd_cap, unit_done, final_done;
  logic          start_ok, zero_cnt;
  logic [1:0]    size_q;
  logic          end_en_q;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic          last_unit;
  logic [AW-1:0] base_addr, raw_addr;
  logic          access;

  assign busy     = (state != SEQ_IDLE);
  assign start_ok = cfg_start && !busy;
  assign zero_cnt = (cfg_count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q   <= UNIT_BYTE;
      end_en_q <= 1'b0;
      done     <= 1'b0;
    end else begin
      if (start_ok) begin
        size_q   <= cfg_unit;
        end_en_q <= cfg_end_en;
        done     <= zero_cnt;
      end else if (final_done) begin
        done <= 1'b1;
      end
    end
  end

  dma_addr_cnt #(.AW(AW), .CW(CW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ok),
    .adv       (unit_done),
    .ld_src    (cfg_src),
    .ld_dst    (cfg_dst),
    .ld_cnt    (cfg_count),
    .size      (size_q),
    .src       (src_q),
    .dst       (dst_q),
    .cnt       (cnt_q),
    .last_unit (last_unit)
  );

  dma_seq_ctrl u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_ok   (start_ok),
    .zero_cnt   (zero_cnt),
    .gnt        (bus_gnt),
    .long_unit  (two_beats(size_q)),
    .last_unit  (last_unit),
    .state      (state),
    .phase      (phase),
    .beat       (beat),
    .rd_cap     (rd_cap),
    .unit_done  (unit_done),
    .final_done (final_done),
    .req        (bus_req),
    .rd         (bus_rd),
    .wr         (bus_wr)
  );

  dma_hold_path u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap    (rd_cap),
    .beat   (beat),
    .size   (size_q),
    .src_a0 (src_q[0]),
    .rdata  (bus_rdata),
    .wdata  (bus_wdata)
  );

  assign access    = bus_rd || bus_wr;
  assign base_addr = bus_rd ? src_q : dst_q;
  assign raw_addr  = base_addr + AW'(beat_offset(beat));

  always_comb begin
    if (!access)                 bus_addr = '0;
    else if (size_q == UNIT_BYTE) bus_addr = raw_addr;
    else                         bus_addr = {raw_addr[AW-1:1], 1'b0};
  end

  assign bus_ben  = access ? lane_sel(size_q, raw_addr[0]) : 2'b00;
  assign xfer_end = end_en_q && access && last_unit;

endmodule

// File: rtl/dma_steal_chk.sv
module dma_steal_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_start,
  input logic          busy,
  input logic          done,
  input logic          bus_req,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [1:0]    bus_ben,
  input logic          xfer_end,
  input logic          unit_done,
  input logic          last_unit,
  input logic          end_en_q,
  input logic [1:0]    size_q,
  input logic [CW-1:0] cnt_q
);

  // R4
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  // R3
  access_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> bus_req);

  // R3
  release_after_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |=> !bus_req);

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R6
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && size_q == 2'b00) |-> ($countones(bus_ben) == 1));

  // R7
  end_only_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |-> (last_unit && end_en_q && (bus_rd || bus_wr)));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_start && busy) |=> ($stable(size_q) && $stable(end_en_q)));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind dma_steal_engine dma_steal_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_start (cfg_start),
  .busy      (busy),
  .done      (done),
  .bus_req   (bus_req),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_ben   (bus_ben),
  .xfer_end  (xfer_end),
  .unit_done (unit_done),
  .last_unit (last_unit),
  .end_en_q  (end_en_q),
  .size_q    (size_q),
  .cnt_q     (cnt_q)
);

// File: tb/test_dma_steal_engine.sv
`timescale 1ns/1ps
module test_dma_steal_engine;

  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
  logic [CW-1:0] cfg_count = '0;
  logic [1:0]    cfg_unit = '0;
  logic          cfg_end_en = 1'b0, cfg_start = 1'b0;
  logic          busy, done, bus_req, bus_rd, bus_wr, xfer_end;
  logic          bus_gnt = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_ben;
  logic [15:0]   bus_wdata, bus_rdata;

  logic [7:0] mem  [0:1023];
  logic [7:0] init [0:1023];
  logic [7:0] expm [0:1023];

  int checks = 0, errors = 0, cycles = 0;
  int rd_cyc = 0, end_cyc = 0, req_rise = 0;
  logic prev_req = 1'b0;

  always #2 clk = ~clk;

  dma_steal_engine #(.AW(AW), .CW(CW)) i_dma_steal_engine (
    .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_count(cfg_count), .cfg_unit(cfg_unit), .cfg_end_en(cfg_end_en),
    .cfg_start(cfg_start), .busy(busy), .done(done), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_ben(bus_ben), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xfer_end(xfer_end)
  );

  // big-endian 16-bit memory: even byte on 15:8
  assign bus_rdata = {mem[{bus_addr[9:1], 1'b0}], mem[{bus_addr[9:1], 1'b1}]};

  always @(posedge clk) begin
    if (bus_wr) begin
      if (bus_ben[1]) mem[{bus_addr[9:1], 1'b0}] <= bus_wdata[15:8];
      if (bus_ben[0]) mem[{bus_addr[9:1], 1'b1}] <= bus_wdata[7:0];
    end
  end

  // arbiter with random grant latency; grant falls once request drops
  always @(posedge clk) begin
    if (!rst_n || !bus_req) bus_gnt <= 1'b0;
    else if (!bus_gnt)      bus_gnt <= (($urandom % 3) == 0);
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (bus_rd) rd_cyc <= rd_cyc + 1;
    if (xfer_end) end_cyc <= end_cyc + 1;
    if (bus_req && !prev_req) req_rise <= req_rise + 1;
    prev_req <= bus_req;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] u);
    return (u == 2'b00) ? 1 : (u == 2'b01) ? 2 : 4;
  endfunction

  function automatic int nbeats(input logic [1:0] u);
    return (u[1]) ? 2 : 1;
  endfunction

  task automatic fill_mem();
    for (int i = 0; i < 1024; i++) begin
      init[i] = 8'($urandom);
      mem[i]  = init[i];
      expm[i] = init[i];
    end
  endtask

  function automatic int mem_mismatch();
    int n = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== expm[i]) n++;
    return n;
  endfunction

  task automatic kick(input int src, input int dst, input int cnt,
                      input logic [1:0] u, input bit en);
    @(negedge clk);
    rd_cyc = 0; end_cyc = 0; req_rise = 0;
    cfg_src = AW'(src); cfg_dst = AW'(dst); cfg_count = CW'(cnt);
    cfg_unit = u; cfg_end_en = en; cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 4000) begin
      @(negedge clk);
      t++;
    end
    chk(done === 1'b1 && busy === 1'b0, req, int'(done), 1);
  endtask

  // full transfer with all result checks
  task automatic run(input int src, input int dst, input int cnt,
                     input logic [1:0] u, input bit en, input string tag);
    int nb = nbytes(u);
    fill_mem();
    for (int k = 0; k < cnt * nb; k++) expm[(dst + k) & 1023] = init[(src + k) & 1023];
    kick(src, dst, cnt, u, en);
    chk(busy === 1'b1 && done === 1'b0, {tag, " R8 start"}, int'(busy), 1);
    wait_done({tag, " R8 done"});
    chk(mem_mismatch() == 0, {tag, " R1 R5 copy"}, mem_mismatch(), 0);
    chk(rd_cyc == cnt * nbeats(u) * 2, {tag, " R4 read cycles"}, rd_cyc, cnt * nbeats(u) * 2);
    chk(req_rise == cnt, {tag, " R3 request per unit"}, req_rise, cnt);
    chk(end_cyc == (en ? nbeats(u) * 4 : 0), {tag, " R7 end cycles"}, end_cyc,
        en ? nbeats(u) * 4 : 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0d1a));
    fill_mem();
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(busy === 1'b0 && done === 1'b0 && bus_req === 1'b0 && xfer_end === 1'b0,
        "R8 reset", int'(busy | done | bus_req | xfer_end), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R6 bytes at odd and even addresses
    run(16'h011, 16'h233, 5, 2'b00, 1'b1, "R6 bytes odd");
    run(16'h040, 16'h280, 4, 2'b00, 1'b0, "R6 bytes even");
    // R1 words
    run(16'h020, 16'h244, 3, 2'b01, 1'b1, "R1 words");
    // R2 longwords: aligned, source unaligned, destination unaligned, encoding 11
    run(16'h100, 16'h300, 3, 2'b10, 1'b1, "R2 long aligned");
    run(16'h102, 16'h300, 3, 2'b10, 1'b1, "R2 long src+2");
    run(16'h100, 16'h306, 2, 2'b10, 1'b0, "R2 long dst+2");
    run(16'h0f6, 16'h20a, 2, 2'b11, 1'b1, "R2 long code 11");
    // R5 single unit stops after one
    run(16'h055, 16'h377, 1, 2'b00, 1'b1, "R5 single unit");

    // R9 start while busy is ignored
    begin
      fill_mem();
      for (int k = 0; k < 12; k++) expm[(16'h260 + k) & 1023] = init[(16'h060 + k) & 1023];
      kick(16'h060, 16'h260, 3, 2'b10, 1'b0);
      repeat (5) @(negedge clk);
      chk(busy === 1'b1, "R9 busy before second start", int'(busy), 1);
      cfg_src = 32'h0; cfg_dst = 32'h380; cfg_count = 16'd8; cfg_unit = 2'b00;
      cfg_end_en = 1'b1; cfg_start = 1'b1;
      @(negedge clk);
      cfg_start = 1'b0;
      wait_done("R9 done");
      chk(mem_mismatch() == 0, "R9 original transfer only", mem_mismatch(), 0);
      chk(end_cyc == 0, "R9 end enable unchanged", end_cyc, 0);
    end

    // R10 zero count
    kick(16'h010, 16'h210, 0, 2'b01, 1'b1);
    chk(done === 1'b1 && busy === 1'b0, "R10 zero count done", int'(done), 1);
    repeat (4) @(negedge clk);
    chk(req_rise == 0 && rd_cyc == 0, "R10 no bus activity", req_rise + rd_cyc, 0);

    // random mix
    for (int n = 0; n < 24; n++) begin
      logic [1:0] u;
      int s, d, c;
      u = 2'($urandom % 4);
      c = 1 + int'($urandom % 6);
      s = int'($urandom % 32'h1c0);
      d = 32'h200 + int'($urandom % 32'h1c0);
      if (u != 2'b00) begin s = s & ~1; d = d & ~1; end
      run(s, d, c, u, 1'($urandom), "R1 R2 R5 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule